// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital output side of a converter. An internal sequencer counts out a fixed conversion period. At the end of each period it tries to place a fresh result, taken from a stand-in sample bus, into a shift register. A ready flag tells the host when a fresh, unread word is waiting. The host selects the port with an active-low select, which may be asserted at any time. It then toggles a serial clock and receives the word most significant bit first, on a data line that is only driven while the port is selected and holds data.

Both host inputs come from outside the master clock domain. Each passes through a two-flop synchronizer, and edges are found on the synchronized serial clock. Shifting is two-phase. The first rising edge after the top bit appears only arms the shifter. Only the falling edges after that move the next bit out. The sample bus has no valid/ready handshake. It is sampled on the reload edge, and the source cannot be back-pressured. A reload the port refuses is simply dropped, and the next conversion brings a newer value. The tri-state data pin is modelled as a data/enable pair.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the ready flag is 1, the data enable is 0 and the port is empty.
- R2: A reload attempt occurs every CONV_CYCLES (default 1624) master clocks. The first attempt is on the 1624th rising clock edge after reset is released.
- R3: The ready flag is 1 during the two master clock cycles before every reload attempt, whether the port is full or empty.
- R4: A successful reload drives the ready flag to 0 on that edge. Outside the pre-reload window the flag stays 0 while the port holds a word that has not been fully read.
- R5: On a reload attempt the new sample is loaded only if the port is empty or the synchronized select is high (deselected). Otherwise the attempt is skipped, and the unread word and its read position are kept.
- R6: The data enable is 1 exactly when the port holds a word and the synchronized select is low. While enabled, the data output carries the current bit, starting with bit DATA_W-1. While disabled, the data output is 0.
- R7: A falling serial clock edge seen before the shifter has been armed has no effect. The first rising edge honoured while the port is selected arms it.
- R8: Once armed, each honoured falling edge presents the next lower bit. The W bits read this way equal the sample bus value captured on the reload edge.
- R9: The honoured falling edge seen while bit 0 is presented empties the port. The data enable drops to 0 and the ready flag returns to 1.
- R10: Serial clock edges are honoured only after the synchronized select has been low for CS_HOLD (default 2) master clocks. An edge that arrives together with the select is ignored.
- R11: Raising the select during a read disables the output and disarms the shifter, but the port stays full. If the host selects again before the next reload, the read resumes at the same bit after a new arming rising edge. If the port is still deselected at the next reload, it takes the new sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | DATA_W | Stand-in conversion result, sampled on a successful reload edge |
| cs_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdata_o | output | 1 | Serial data value (0 when not enabled) |
| sdata_oe | output | 1 | Serial data drive enable (0 means high impedance) |
| drdy | output | 1 | Ready flag, 0 when an unread word is waiting |

## Verification
The bench targets these corner cases:
- A word left unread under an active select across a reload. A design that reloads regardless would return the newer sample.
- A port left deselected and unread. A design that demands emptiness would keep returning the stale word.
- A falling edge sent while the top bit is already out, and a rising edge that arrives together with the select. A design that shifts on either one skips the top bit.
- Deselecting halfway through a read and then selecting again. This exposes designs that lose their place, clear the word, or resume without re-arming.
- The exact cycle the ready flag rises before each reload, and the exact period between reloads.

A cycle-accurate reference model catches any off-by-one in these timings.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  // Occupancy / shifting phase of the result port
  typedef enum logic [1:0] {
    PORT_EMPTY  = 2'd0,
    PORT_LOADED = 2'd1,  // word present, shifter not armed
    PORT_ARMED  = 2'd2   // word present, falling edges shift
  } port_state_e;

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int CONV_CYCLES = 1624,
  parameter int DRDY_LEAD   = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic upd_stb,   // reload attempt on this cycle's edge
  output logic warn_win   // pre-reload window
);

  localparam int CW = $clog2(CONV_CYCLES);
  localparam logic [CW-1:0] LAST    = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] WARN_AT = CW'(CONV_CYCLES - 1 - DRDY_LEAD);

  logic [CW-1:0] cnt;

  assign upd_stb = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      warn_win <= 1'b0;
    end else begin
      cnt <= upd_stb ? '0 : cnt + 1'b1;
      if (cnt == WARN_AT) warn_win <= 1'b1;
      else if (upd_stb)   warn_win <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter
  import adc_port_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CS_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_sync,
  input  logic              sclk_sync,
  input  logic              upd_stb,
  input  logic [DATA_W-1:0] load_data,
  output logic              port_full,
  output logic              port_armed,
  output logic [DATA_W-1:0] shreg,
  output logic              sdata_o,
  output logic              sdata_oe
);

  localparam int PW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HW = $clog2(CS_HOLD + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(CS_HOLD);
  localparam logic [PW-1:0] POS_TOP  = PW'(DATA_W - 1);

  port_state_e   state;
  logic [PW-1:0] pos;
  logic [HW-1:0] hold_cnt;
  logic          sclk_d;
  logic          sclk_rise, sclk_fall, honoured, do_load;

  assign sclk_rise = sclk_sync & ~sclk_d;
  assign sclk_fall = ~sclk_sync & sclk_d;
  assign honoured  = ~cs_sync & (hold_cnt == HOLD_MAX);
  assign do_load   = upd_stb & ((state == PORT_EMPTY) | cs_sync);

  // select qualification and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      sclk_d <= sclk_sync;
      if (cs_sync)                    hold_cnt <= '0;
      else if (hold_cnt != HOLD_MAX)  hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // port state, word and bit position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PORT_EMPTY;
      shreg <= '0;
      pos   <= '0;
    end else if (do_load) begin
      state <= PORT_LOADED;
      shreg <= load_data;
      pos   <= POS_TOP;
    end else if (cs_sync) begin
      if (state == PORT_ARMED) state <= PORT_LOADED;
    end else if (honoured) begin
      unique case (state)
        PORT_LOADED: if (sclk_rise) state <= PORT_ARMED;
        PORT_ARMED: begin
          if (sclk_fall) begin
            if (pos == '0) begin
              state <= PORT_EMPTY;
            end else begin
              shreg <= {shreg[DATA_W-2:0], 1'b0};
              pos   <= pos - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign port_full  = (state != PORT_EMPTY);
  assign port_armed = (state == PORT_ARMED);
  assign sdata_oe   = port_full & ~cs_sync;
  assign sdata_o    = sdata_oe & shreg[DATA_W-1];

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 1624,
  parameter int DRDY_LEAD   = 2,
  parameter int CS_HOLD     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              cs_n,
  input  logic              sclk,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic              drdy
);

  localparam int NSYNC = 2;
  // bit 0: select (idles high), bit 1: serial clock (idles low)
  localparam logic [NSYNC-1:0] SYNC_RST = 2'b01;

  logic [NSYNC-1:0] raw_in, synced;
  logic             cs_sync, sclk_sync;
  logic             upd_stb, warn_win;
  logic             port_full, port_armed;
  logic [DATA_W-1:0] shreg;

  assign raw_in = {sclk, cs_n};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    adc_bit_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST[g])
    ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in[g]),
      .q    (synced[g])
    );
  end

  assign cs_sync   = synced[0];
  assign sclk_sync = synced[1];

  adc_conv_sequencer #(
    .CONV_CYCLES(CONV_CYCLES),
    .DRDY_LEAD  (DRDY_LEAD)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_stb (upd_stb),
    .warn_win(warn_win)
  );

  adc_serial_shifter #(
    .DATA_W (DATA_W),
    .CS_HOLD(CS_HOLD)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_sync   (cs_sync),
    .sclk_sync (sclk_sync),
    .upd_stb   (upd_stb),
    .load_data (sample_in),
    .port_full (port_full),
    .port_armed(port_armed),
    .shreg     (shreg),
    .sdata_o   (sdata_o),
    .sdata_oe  (sdata_oe)
  );

  assign drdy = warn_win | ~port_full;

endmodule

// File: rtl/adc_port_checker.sv
module adc_port_checker #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 1624
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_stb,
  input logic              cs_sync,
  input logic              drdy,
  input logic              port_full,
  input logic              port_armed,
  input logic [DATA_W-1:0] shreg
);

  logic [31:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap <= '0;
    else if (upd_stb) gap <= '0;
    else              gap <= gap + 1'b1;
  end

  p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> gap == 32'(CONV_CYCLES - 1));

  p_drdy_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> drdy && $past(drdy));

  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && (!port_full || cs_sync) |=> port_full && !drdy);

  p_skip_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && port_full && !cs_sync |=> port_full && shreg == $past(shreg));

  p_arm_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_armed) |-> $past(port_full) && !$past(cs_sync));

  p_shift_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    port_full && $past(port_full) && !$past(upd_stb) && shreg != $past(shreg)
      |-> $past(port_armed));

  p_empty_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_full) |-> $past(port_armed));

  p_desel_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> !port_armed);

endmodule

bind adc_serial_port adc_port_checker #(
  .DATA_W     (DATA_W),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_stb   (upd_stb),
  .cs_sync   (cs_sync),
  .drdy      (drdy),
  .port_full (port_full),
  .port_armed(port_armed),
  .shreg     (shreg)
);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int CONV       = 1624;
  localparam int LEAD       = 2;
  localparam int HOLD       = 2;
  localparam int H          = 6;     // half period of host serial clock, in master clocks

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] sample_in;
  logic         cs_n, sclk;
  logic         sdata_o, sdata_oe, drdy;

  int n_checks = 0;
  int n_errors = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] rd_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_in(sample_in),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdata_o  (sdata_o),
    .sdata_oe (sdata_oe),
    .drdy     (drdy)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_hold;
  bit m_win, m_armed;
  bit m_cs1, m_cs2, m_sc1, m_sc2, m_sc3;
  bit m_q[$];

  task automatic model_reset();
    m_cnt = 0; m_hold = 0; m_win = 0; m_armed = 0;
    m_cs1 = 1; m_cs2 = 1; m_sc1 = 0; m_sc2 = 0; m_sc3 = 0;
    m_q.delete();
  endtask

  task automatic model_step();
    bit rise, fall, act, upd;
    rise = m_sc2 && !m_sc3;
    fall = !m_sc2 && m_sc3;
    act  = !m_cs2 && (m_hold >= HOLD);
    upd  = (m_cnt == CONV - 1);
    if (upd && (m_q.size() == 0 || m_cs2)) begin
      m_q.delete();
      for (int b = W - 1; b >= 0; b--) m_q.push_back(sample_in[b]);
      m_armed = 0;
    end else if (m_cs2) begin
      m_armed = 0;
    end else if (act && m_q.size() > 0) begin
      if (!m_armed && rise) m_armed = 1;
      else if (m_armed && fall) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_armed = 0;
      end
    end
    if (m_cnt == CONV - 1 - LEAD) m_win = 1;
    else if (upd)                 m_win = 0;
    m_cnt  = upd ? 0 : m_cnt + 1;
    m_hold = m_cs2 ? 0 : ((m_hold < HOLD) ? m_hold + 1 : m_hold);
    m_cs2 = m_cs1; m_cs1 = cs_n;
    m_sc3 = m_sc2; m_sc2 = m_sc1; m_sc1 = sclk;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e_oe, e_sd, e_dr;
    if (!rst_n) model_reset();
    else        model_step();
    if (compare_on && !done) begin
      e_oe = (m_q.size() > 0) && !m_cs2;
      e_sd = e_oe ? m_q[0] : 1'b0;
      e_dr = m_win || (m_q.size() == 0);
      chk(drdy === e_dr,      "R3/R4 drdy vs model",      int'(drdy),     int'(e_dr));
      chk(sdata_oe === e_oe,  "R6/R11 enable vs model",   int'(sdata_oe), int'(e_oe));
      chk(sdata_o === e_sd,   "R8 data vs model",         int'(sdata_o),  int'(e_sd));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_load();
    while (drdy !== 1'b1) wait_cyc(1);
    while (drdy !== 1'b0) wait_cyc(1);
  endtask

  task automatic read_bits(input int n, input int top);
    for (int i = 0; i < n; i++) begin
      rd_word[top - i] = sdata_o;
      sclk = 1'b1; wait_cyc(H);
      sclk = 1'b0; wait_cyc(H);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sample_in = 16'hA5C3; rd_word = '0;
    compare_on = 1'b1;
    wait_cyc(3);
    chk(drdy === 1'b1,     "R1 reset drdy",   int'(drdy),     1);
    chk(sdata_oe === 1'b0, "R1 reset enable", int'(sdata_oe), 0);
    rst_n = 1'b1;

    // R2: first reload on the 1624th edge
    n = 0;
    do begin wait_cyc(1); n++; end while (drdy !== 1'b0 && n < 5000);
    chk(n == CONV, "R2 first reload cycle", n, CONV);
    sample_in = 16'h3C5A;

    // R3: flag rises exactly two cycles before next reload; deselected full port reloads (R5)
    n = 0;
    do begin wait_cyc(1); n++; end while (drdy !== 1'b1 && n < 5000);
    chk(n == CONV - LEAD, "R3 flag rise position", n, CONV - LEAD);
    n = 0;
    do begin wait_cyc(1); n++; end while (drdy !== 1'b0 && n < 50);
    chk(n == LEAD, "R4 flag low after reload", n, LEAD);

    cs_n = 1'b0; wait_cyc(4);
    chk(sdata_oe === 1'b1, "R6 enable on select", int'(sdata_oe), 1);
    chk(sdata_o === 1'b0,  "R6 top bit shown",    int'(sdata_o),  0);
    read_bits(W, W - 1);
    chk(rd_word == 16'h3C5A, "R5 deselected reload word", int'(rd_word), 16'h3C5A);
    chk(sdata_oe === 1'b0, "R9 enable after last bit", int'(sdata_oe), 0);
    chk(drdy === 1'b1,     "R9 flag after last bit",   int'(drdy),     1);
    cs_n = 1'b1;

    // R5: selected unread word survives a reload
    sample_in = 16'h8E71;
    wait_load();
    cs_n = 1'b0; wait_cyc(4);
    sample_in = 16'h0F0F;
    wait_load();
    read_bits(W, W - 1);
    chk(rd_word == 16'h8E71, "R5 skipped reload keeps word", int'(rd_word), 16'h8E71);
    cs_n = 1'b1;

    // R7: falling edge before arming ignored
    sample_in = 16'hA0DE;
    wait_load();
    sclk = 1'b1; wait_cyc(4);
    cs_n = 1'b0; wait_cyc(H);
    sclk = 1'b0; wait_cyc(H);
    chk(sdata_o === 1'b1, "R7 early fall ignored", int'(sdata_o), 1);
    read_bits(W, W - 1);
    chk(rd_word == 16'hA0DE, "R8 word after early fall", int'(rd_word), 16'hA0DE);
    cs_n = 1'b1;

    // R10: rising edge together with select is not honoured
    sample_in = 16'h5B27;
    wait_load();
    cs_n = 1'b0; sclk = 1'b1; wait_cyc(H);
    sclk = 1'b0; wait_cyc(H);
    chk(sdata_o === 1'b0, "R10 edge during hold ignored", int'(sdata_o), 0);
    read_bits(W, W - 1);
    chk(rd_word == 16'h5B27, "R10 word after hold", int'(rd_word), 16'h5B27);
    cs_n = 1'b1;

    // R11: deselect mid-read, then resume
    sample_in = 16'h9C63;
    wait_load();
    cs_n = 1'b0; wait_cyc(4);
    read_bits(5, W - 1);
    cs_n = 1'b1; wait_cyc(4);
    chk(sdata_oe === 1'b0, "R11 enable off when deselected", int'(sdata_oe), 0);
    chk(drdy === 1'b0,     "R11 port stays full",           int'(drdy),     0);
    cs_n = 1'b0; wait_cyc(4);
    chk(sdata_o === 1'b1,  "R11 resume bit", int'(sdata_o), 1);
    read_bits(W - 5, W - 6);
    chk(rd_word == 16'h9C63, "R11 resumed word", int'(rd_word), 16'h9C63);
    cs_n = 1'b1;

    // R11: partial read abandoned, deselected port reloads
    sample_in = 16'h2DB4;
    wait_load();
    cs_n = 1'b0; wait_cyc(4);
    read_bits(3, W - 1);
    cs_n = 1'b1;
    sample_in = 16'hE1F0;
    wait_load();
    cs_n = 1'b0; wait_cyc(4);
    read_bits(W, W - 1);
    chk(rd_word == 16'hE1F0, "R11 reload after abandoned read", int'(rd_word), 16'hE1F0);
    cs_n = 1'b1;
    wait_cyc(8);

    finish_run();
  end

endmodule